// File: doc/BRIEF.md
# Multi-Channel Comparator Event Timer

This block is a memory-mapped event timer. A single 32-bit main counter ticks once per clock while the global enable is set, and a parameterised number of comparator channels watch it. Each channel raises its status bit when the counter reaches its comparator value. It can also drive an interrupt line, either as a one-cycle pulse or as a level held until software acknowledges the status bit. A channel runs either as one-shot or, where it is built with the periodic capability, as a self-reloading periodic timer.

Software reaches the block through a flat 32-bit register port: a write strobe, a byte address and combinational read data. The interrupt lines form a small vector. A channel lands on the line named by its route field, provided its read-only capability mask allows that line. When the fixed-line mode is on, channels 0 and 1 are instead tied to lines 0 and 8.

Each channel holds two small state machines. The run machine has two states. `CH_IDLE` moves to `CH_ARMED` on a comparator write that loads a match time ("arm"). `CH_ARMED` moves back to `CH_IDLE` on a one-shot match ("expire"), and stays in `CH_ARMED` on a periodic match ("reload"). The write-sequence machine has three states. `WS_DIRECT` moves to `WS_NEXT` on a configuration write with set-value and periodic type ("prime"). `WS_NEXT` moves to `WS_PERIOD` on a comparator write ("load match"). `WS_PERIOD` moves to `WS_DIRECT` on the next comparator write ("load period"). Any other configuration write returns the machine to `WS_DIRECT` ("cancel").

Top module: `evtimer`

Register map (byte addresses): 0x000 capabilities (RO), 0x004 tick period in femtoseconds (RO), 0x010 global control, 0x020 status (write-one-to-clear), 0x0F0 main counter (read/write), channel c at 0x100 + 0x20*c with configuration at +0x0, route capability at +0x4 and comparator at +0x8.

## Requirements
- R1: The main counter (0x0F0) increments by one on every clock while global control bit 0 (enable) is 1. It holds its value while that bit is 0. A write to 0x0F0 loads the counter.
- R2: The capabilities word reads {VENDOR[31:16], bit15 = 1 (fixed-line capable), bit13 = 0 (32-bit counter), bits 12:8 = NUM_CH-1, REV[7:0]}. The period word reads PERIOD_FS, which is nonzero.
- R3: A match on channel c sets status bit c. Writing 1 to status bit c clears it, and writing 0 leaves it unchanged.
- R4: An armed channel matches on a clock edge where the counter is enabled and equals its comparator. A one-shot channel then disarms and does not fire again until its comparator is rewritten.
- R5: For a periodic channel in direct write mode, a comparator write loads both the match time and the period. Each match adds the period to the comparator.
- R6: Writing configuration with bit 6 (set-value) and bit 3 (periodic) both 1 makes the next comparator write load the match time and the following one load the period. The set-value bit reads back as 0.
- R7: A channel with configuration bit 1 = 0 (edge) and bit 2 = 1 (interrupt enable) drives a one-cycle pulse in the cycle after its match edge.
- R8: A channel with configuration bit 1 = 1 (level) and bit 2 = 1 holds its line high while its status bit is set, and drops it once the bit is cleared.
- R9: Configuration bits 13:9 choose the line. The word at +0x4 is the channel's route-capability mask (bit n = line n allowed). A route to a line outside that mask drives no line, though the status bit is still set.
- R10: With global control bit 1 set, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R11: Configuration bit 4 reads 1 only on periodic-capable channels, and bit 8 (32-bit mode) always reads 1. On a channel without the periodic capability, bit 3 reads 0, writing it has no effect, and the channel stays one-shot.
- R12: Matching works across counter wraparound: a comparator value just past 0xFFFFFFFF matches after the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one write per clock |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | IRQ_LINES | Routed interrupt lines |

## Verification
The assertions assume that a comparator write and a configuration write never reach the same channel in one cycle. They also assume that the counter is not loaded in a cycle where its freeze or step behaviour is checked, so those properties exclude load cycles. The bench issues at most one register write per clock and changes counters and comparators only while the global enable is off. It clears the status register between scenarios, so no earlier match can leak into a later check.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int DATA_W = 32;

    localparam logic [11:0] A_CAPS   = 12'h000;
    localparam logic [11:0] A_PERIOD = 12'h004;
    localparam logic [11:0] A_CTRL   = 12'h010;
    localparam logic [11:0] A_STATUS = 12'h020;
    localparam logic [11:0] A_COUNT  = 12'h0F0;
    localparam int          CH_BASE   = 'h100;
    localparam int          CH_STRIDE = 'h20;
    localparam logic [4:0]  OFF_CFG  = 5'h00;
    localparam logic [4:0]  OFF_RCAP = 5'h04;
    localparam logic [4:0]  OFF_CMP  = 5'h08;

    localparam int B_LEVEL  = 1;
    localparam int B_INTEN  = 2;
    localparam int B_PERIOD = 3;
    localparam int B_PCAP   = 4;
    localparam int B_SETVAL = 6;
    localparam int B_M32    = 8;
    localparam int B_ROUTE  = 9;
    localparam int ROUTE_W  = 5;

    typedef enum logic {CH_IDLE, CH_ARMED} ch_run_e;
    typedef enum logic [1:0] {WS_DIRECT, WS_NEXT, WS_PERIOD} ch_wseq_e;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (run)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    a_r1_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q));
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter bit PER_CAP = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cmp_we,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  cnt,
    input  logic               cnt_run,
    input  logic               status_bit,
    output logic               match_o,
    output logic               req_o,
    output logic [ROUTE_W-1:0] route_o,
    output logic [DATA_W-1:0]  cfg_rd,
    output logic [DATA_W-1:0]  cmp_rd
);
    ch_run_e  run_q,  run_d;
    ch_wseq_e ws_q,   ws_d;
    logic [DATA_W-1:0] cmp_q, cmp_d, per_q, per_d;
    logic int_en_q, level_q, periodic_q, pulse_q;
    logic [ROUTE_W-1:0] route_q;
    logic match;

    assign match = (run_q == CH_ARMED) && cnt_run && (cnt == cmp_q);

    // next-state process
    always_comb begin
        run_d = run_q;
        ws_d  = ws_q;
        cmp_d = cmp_q;
        per_d = per_q;
        if (match) begin
            if (periodic_q) cmp_d = cmp_q + per_q;   // reload
            else            run_d = CH_IDLE;         // expire
        end
        if (cfg_we) begin
            if (wdata[B_SETVAL] && wdata[B_PERIOD] && PER_CAP) ws_d = WS_NEXT; // prime
            else                                                ws_d = WS_DIRECT; // cancel
        end
        if (cmp_we) begin
            unique case (ws_q)
                WS_DIRECT: begin
                    cmp_d = wdata;
                    if (periodic_q) per_d = wdata;
                    run_d = CH_ARMED;                // arm
                end
                WS_NEXT: begin
                    cmp_d = wdata;                   // load match
                    run_d = CH_ARMED;
                    ws_d  = WS_PERIOD;
                end
                WS_PERIOD: begin
                    per_d = wdata;                   // load period
                    ws_d  = WS_DIRECT;
                end
                default: ws_d = WS_DIRECT;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= CH_IDLE;
            ws_q  <= WS_DIRECT;
            cmp_q <= '0;
            per_q <= '0;
        end else begin
            run_q <= run_d;
            ws_q  <= ws_d;
            cmp_q <= cmp_d;
            per_q <= per_d;
        end
    end

    // configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_en_q   <= 1'b0;
            level_q    <= 1'b0;
            periodic_q <= 1'b0;
            route_q    <= '0;
        end else if (cfg_we) begin
            int_en_q   <= wdata[B_INTEN];
            level_q    <= wdata[B_LEVEL];
            periodic_q <= wdata[B_PERIOD] & PER_CAP;
            route_q    <= wdata[B_ROUTE +: ROUTE_W];
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= match && int_en_q && !level_q;
    end

    always_comb begin
        cfg_rd                     = '0;
        cfg_rd[B_LEVEL]            = level_q;
        cfg_rd[B_INTEN]            = int_en_q;
        cfg_rd[B_PERIOD]           = periodic_q;
        cfg_rd[B_PCAP]             = PER_CAP;
        cfg_rd[B_M32]              = 1'b1;
        cfg_rd[B_ROUTE +: ROUTE_W] = route_q;
    end

    assign cmp_rd  = cmp_q;
    assign route_o = route_q;
    assign match_o = match;
    assign req_o   = level_q ? (status_bit && int_en_q) : pulse_q;

    a_r4_oneshot_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !periodic_q && !cmp_we) |=> (run_q == CH_IDLE));
    a_r5_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (match && periodic_q && !cmp_we) |=> (cmp_q == $past(cmp_q) + $past(per_q)));
    a_r6_period_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && ws_q == WS_PERIOD) |=> $stable(cmp_q));
    a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q && int_en_q && status_bit) |-> req_o);
endmodule

// File: rtl/evt_router.sv
module evt_router
    import evt_pkg::*;
#(
    parameter int          NUM_CH    = 4,
    parameter int          IRQ_LINES = 24,
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
    input  logic [NUM_CH-1:0]         req,
    input  logic [NUM_CH*ROUTE_W-1:0] routes,
    input  logic                      fixed_mode,
    output logic [IRQ_LINES-1:0]      irq_o
);
    localparam logic [ROUTE_W-1:0] FIXED_LINE0 = 5'd0;
    localparam logic [ROUTE_W-1:0] FIXED_LINE1 = 5'd8;

    always_comb begin
        logic [ROUTE_W-1:0] tgt;
        logic               ok;
        irq_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            tgt = routes[c*ROUTE_W +: ROUTE_W];
            ok  = ROUTE_CAP[tgt];
            if (fixed_mode && c < 2) begin
                tgt = (c == 0) ? FIXED_LINE0 : FIXED_LINE1;
                ok  = 1'b1;
            end
            if (req[c] && ok) begin
                for (int l = 0; l < IRQ_LINES; l++) begin
                    if (int'(tgt) == l) irq_o[l] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/evtimer.sv
module evtimer
    import evt_pkg::*;
#(
    parameter int          NUM_CH       = 4,
    parameter int          IRQ_LINES    = 24,
    parameter int          ADDR_W       = 12,
    parameter logic [15:0] VENDOR       = 16'h1A2B,
    parameter logic [7:0]  REV          = 8'h03,
    parameter logic [31:0] PERIOD_FS    = 32'd20_000_000,
    parameter logic [31:0] ROUTE_CAP    = 32'h00F0_0000,
    parameter logic [7:0]  PERIODIC_CAP = 8'b0000_1101
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [IRQ_LINES-1:0] irq_o
);
    localparam logic [DATA_W-1:0] CAPS_WORD =
        {VENDOR, 1'b1, 1'b0, 1'b0, 5'(NUM_CH - 1), REV};

    logic                      en_q, fixed_q;
    logic [NUM_CH-1:0]         status_q, match_v, req_v, clr_v;
    logic [DATA_W-1:0]         cnt;
    logic [NUM_CH*ROUTE_W-1:0] routes;
    logic [DATA_W-1:0]         cfg_rd [NUM_CH];
    logic [DATA_W-1:0]         cmp_rd [NUM_CH];
    logic                      wr_ctrl, wr_status, wr_count;

    assign wr_ctrl   = reg_we && (reg_addr == ADDR_W'(A_CTRL));
    assign wr_status = reg_we && (reg_addr == ADDR_W'(A_STATUS));
    assign wr_count  = reg_we && (reg_addr == ADDR_W'(A_COUNT));
    assign clr_v     = wr_status ? reg_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            fixed_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q    <= reg_wdata[0];
            fixed_q <= reg_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_v) | match_v;
    end

    evt_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(en_q),
        .load(wr_count), .load_val(reg_wdata), .cnt_o(cnt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + c * CH_STRIDE);
        logic cfg_we, cmp_we;
        assign cfg_we = reg_we && (reg_addr == (BASE | ADDR_W'(OFF_CFG)));
        assign cmp_we = reg_we && (reg_addr == (BASE | ADDR_W'(OFF_CMP)));
        evt_channel #(.PER_CAP(PERIODIC_CAP[c])) u_ch (
            .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cmp_we(cmp_we),
            .wdata(reg_wdata), .cnt(cnt), .cnt_run(en_q),
            .status_bit(status_q[c]), .match_o(match_v[c]), .req_o(req_v[c]),
            .route_o(routes[c*ROUTE_W +: ROUTE_W]),
            .cfg_rd(cfg_rd[c]), .cmp_rd(cmp_rd[c])
        );
    end

    evt_router #(.NUM_CH(NUM_CH), .IRQ_LINES(IRQ_LINES), .ROUTE_CAP(ROUTE_CAP)) u_rt (
        .req(req_v), .routes(routes), .fixed_mode(fixed_q), .irq_o(irq_o)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_W'(A_CAPS):   reg_rdata = CAPS_WORD;
            ADDR_W'(A_PERIOD): reg_rdata = PERIOD_FS;
            ADDR_W'(A_CTRL):   reg_rdata = {30'b0, fixed_q, en_q};
            ADDR_W'(A_STATUS): reg_rdata = DATA_W'(status_q);
            ADDR_W'(A_COUNT):  reg_rdata = cnt;
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (reg_addr == ADDR_W'(CH_BASE + c * CH_STRIDE) + ADDR_W'(OFF_CFG))
                        reg_rdata = cfg_rd[c];
                    if (reg_addr == ADDR_W'(CH_BASE + c * CH_STRIDE) + ADDR_W'(OFF_RCAP))
                        reg_rdata = ROUTE_CAP;
                    if (reg_addr == ADDR_W'(CH_BASE + c * CH_STRIDE) + ADDR_W'(OFF_CMP))
                        reg_rdata = cmp_rd[c];
                end
            end
        endcase
    end

    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && match_v == '0) |=> ((status_q & $past(reg_wdata[NUM_CH-1:0])) == '0));
    a_r3_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (match_v != '0) |=> ((status_q & $past(match_v)) == $past(match_v)));
    a_r10_fixed_line0: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_q && req_v[0]) |-> irq_o[0]);
    a_r2_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(A_PERIOD)) |-> (reg_rdata != '0));
endmodule

// File: tb/evtimer_bench.sv
module evtimer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [23:0] irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [11:0] CH0 = 12'h100, CH1 = 12'h120, CH2 = 12'h140, CH3 = 12'h160;
    localparam logic [31:0] F_LVL = 32'h2, F_IEN = 32'h4, F_PER = 32'h8, F_SV = 32'h40;

    always #10 clk = ~clk;

    evtimer u_evtimer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_line(input int line, input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (irq_o[line]) begin n = i; break; end
        end
    endtask

    task automatic quiesce();
        wr(12'h010, 0);
        wr(CH0, 0); wr(CH1, 0); wr(CH2, 0); wr(CH3, 0);
        wr(12'h020, 32'hF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h000, d); chk("R2 caps", d, 32'h1A2B_8303);
        rd(12'h004, d); chk("R2 period", d, 32'd20_000_000);
        rd(12'h020, d); chk("R3 status reset", d, 0);
        chk("R7 irq reset", 32'(irq_o), 0);
        rd(CH0, d); chk("R11 cfg ch0 reset", d, 32'h110);
        rd(CH1, d); chk("R11 cfg ch1 reset", d, 32'h100);
    endtask

    task automatic t_counter();
        logic [31:0] d;
        wr(12'h0F0, 5);
        repeat (3) @(negedge clk);
        rd(12'h0F0, d); chk("R1 frozen", d, 5);
        wr(12'h010, 1);
        repeat (4) @(negedge clk);
        rd(12'h0F0, d); chk("R1 counting", d, 9);
        wr(12'h010, 0);
        repeat (3) @(negedge clk);
        rd(12'h0F0, d); chk("R1 freeze again", d, 10);
    endtask

    task automatic t_oneshot();
        logic [31:0] d; int n; int extra;
        quiesce();
        wr(12'h0F0, 100); wr(CH0 + 8, 110); wr(CH0, F_IEN | (20 << 9));
        wr(12'h010, 1);
        wait_line(20, 40, n);
        chk("R4 one-shot latency", n, 11);
        @(negedge clk);
        chk("R7 pulse one cycle", 32'(irq_o[20]), 0);
        rd(12'h020, d); chk("R3 status set", d & 1, 1);
        extra = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (irq_o[20]) extra++; end
        chk("R4 no refire", extra, 0);
        wr(12'h020, 0);
        rd(12'h020, d); chk("R3 write zero keeps", d & 1, 1);
        wr(12'h020, 1);
        rd(12'h020, d); chk("R3 write one clears", d & 1, 0);
    endtask

    task automatic t_periodic_direct();
        logic [31:0] d; int n;
        quiesce();
        wr(12'h0F0, 0); wr(CH3, F_PER | F_IEN | (22 << 9)); wr(CH3 + 8, 6);
        wr(12'h010, 1);
        wait_line(22, 40, n); chk("R5 first match", n, 7);
        rd(CH3 + 8, d); chk("R5 comparator reloaded", d, 12);
        wait_line(22, 40, n); chk("R5 second match", n, 6);
    endtask

    task automatic t_setvalue_level();
        logic [31:0] d; int n;
        quiesce();
        wr(12'h0F0, 40);
        wr(CH2, F_PER | F_SV | F_LVL | F_IEN | (21 << 9));
        rd(CH2, d); chk("R6 set-value reads zero", d & F_SV, 0);
        wr(CH2 + 8, 50); wr(CH2 + 8, 10);
        rd(CH2 + 8, d); chk("R6 period write keeps match", d, 50);
        wr(12'h010, 1);
        wait_line(21, 40, n); chk("R6 match time", n, 11);
        rd(CH2 + 8, d); chk("R6 period applied", d, 60);
        repeat (3) @(negedge clk);
        chk("R8 level held", 32'(irq_o[21]), 1);
        wr(12'h020, 32'h4);
        chk("R8 level dropped", 32'(irq_o[21]), 0);
        wait_line(21, 40, n); chk("R6 second match", n, 6);
    endtask

    task automatic t_not_capable();
        logic [31:0] d; int n; int extra;
        quiesce();
        wr(12'h0F0, 0); wr(CH1, F_PER | F_IEN | (23 << 9));
        rd(CH1, d); chk("R11 periodic bit ignored", d & F_PER, 0);
        wr(CH1 + 8, 5);
        wr(12'h010, 1);
        wait_line(23, 30, n); chk("R11 fires once", n, 6);
        extra = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (irq_o[23]) extra++; end
        chk("R11 stays one-shot", extra, 0);
        rd(CH1 + 8, d); chk("R11 comparator unchanged", d, 5);
    endtask

    task automatic t_route();
        logic [31:0] d;
        quiesce();
        rd(CH0 + 4, d); chk("R9 route capability", d, 32'h00F0_0000);
        wr(12'h0F0, 0); wr(CH0, F_LVL | F_IEN | (3 << 9)); wr(CH0 + 8, 4);
        wr(12'h010, 1);
        repeat (10) @(negedge clk);
        chk("R9 disallowed line silent", 32'(irq_o), 0);
        rd(12'h020, d); chk("R9 status still set", d & 1, 1);
    endtask

    task automatic t_fixed();
        quiesce();
        wr(12'h0F0, 0);
        wr(CH0, F_LVL | F_IEN | (20 << 9)); wr(CH0 + 8, 3);
        wr(CH1, F_LVL | F_IEN | (21 << 9)); wr(CH1 + 8, 5);
        wr(12'h010, 3);
        repeat (10) @(negedge clk);
        chk("R10 line0", 32'(irq_o[0]), 1);
        chk("R10 line8", 32'(irq_o[8]), 1);
        chk("R10 route fields bypassed", 32'(irq_o[21:20]), 0);
    endtask

    task automatic t_wrap();
        int n;
        quiesce();
        wr(12'h0F0, 32'hFFFF_FFFE); wr(CH0, F_IEN | (20 << 9)); wr(CH0 + 8, 1);
        wr(12'h010, 1);
        wait_line(20, 20, n); chk("R12 wrap match", n, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_counter();
        t_oneshot();
        t_periodic_direct();
        t_setvalue_level();
        t_not_capable();
        t_route();
        t_fixed();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule